// File: doc/BRIEF.md
# Reload Event Counter with Toggle Output

This block is an up-counter that advances on one of two kinds of tick: a system clock divided by a power of two, or a chosen transition on an external event pin. When the count reaches its top value, the next tick loads the count from a reload register instead of wrapping. That reload sets a sticky overflow flag, can raise an interrupt request, and toggles a toggle output. The top value is all ones of the counter width, or 0xFF when narrow mode is selected. A compare register can also toggle the output. This gives a divided or pulse-width waveform on the toggle pin, and a periodic interrupt every N counted events.

Software reaches the block through a simple register port. A write happens on the clock edge when `wr_en` is high. A read is combinational on `rd_data`. A two-state machine controls the output level. The states are ST_STOP and ST_RUN. Transition T_START moves from ST_STOP to ST_RUN when the run bit is written as 1. Transition T_HALT moves from ST_RUN to ST_STOP when the run bit is written as 0. In ST_STOP, a control write copies the polarity bit straight onto the output level. In ST_RUN, only counter events change the level.

Top module: `evt_reload_ctr`

## Requirements
- R1: Register map. Address 0 is control, address 1 is count, address 2 is reload, address 3 is compare, address 4 is the flag. Control bits are: bit0 run, bit1 interrupt enable, bit2 output enable, bit3 polarity, bit4 narrow (8-bit) mode, bits[6:5] edge select, bit7 event-pin mode, bits[10:8] prescale exponent. The flag is bit0 of address 4. Writes take effect on the clock edge with `wr_en` high. `rd_data` shows the addressed register in the same cycle. Unused addresses read 0.
- R2: After reset, every register reads 0, the machine is in ST_STOP, and `tgl_pin_o`, `tgl_oe_o` and `irq_o` are low.
- R3: With bit7 clear and the block running, the count advances once every 2^P clocks, where P is bits[10:8]. The first advance comes 2^P clocks after the run write.
- R4: With bit7 set, edge select 01 counts rising edges, 10 counts falling edges, 11 counts both, and 00 counts nothing. An edge on `ev_pin_i` advances the count on the third rising clock edge after the pin changes.
- R5: A tick while the count equals the top value loads the reload value. The top value is 0xFFFF, or 0xFF in narrow mode. With reload 0xFFF8, an overflow happens every 8 ticks.
- R6: Each overflow sets the flag, and the flag stays set. Writing bit0 = 0 to address 4 clears it. Writing 1 has no effect. An overflow in the same cycle as a clear leaves the flag set.
- R7: `irq_o` is high exactly when the flag and the interrupt enable are both set.
- R8: Each overflow toggles the output level. `tgl_oe_o` follows the output-enable bit. `tgl_pin_o` shows the level while enabled and is 0 otherwise.
- R9: A tick while the count equals the compare value toggles the level. When compare equals reload, a second transition follows one tick after each overflow.
- R10: When the compare value equals the top value, the compare and overflow events fall on the same tick and the level changes only once.
- R11: A control write in ST_STOP sets the level to the polarity bit. A polarity write in ST_RUN leaves the level unchanged.
- R12: In narrow mode, count, reload, compare and count writes use only the low 8 bits, and the count reads back with the upper bits zero.
- R13: A count write loads the written value even on a tick cycle. In ST_STOP the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data for `rd_addr` |
| ev_pin_i | input | 1 | External event pin (asynchronous) |
| tgl_pin_o | output | 1 | Toggle output level (0 when disabled) |
| tgl_oe_o | output | 1 | Toggle output enable |
| irq_o | output | 1 | Interrupt request |

## Verification
Register writes and timer ticks act at the clock edge that ends the cycle in which they are presented. The count, flag, output level and `irq_o` therefore change at that edge. `rd_data` follows `rd_addr` within the same cycle. A change on the event pin is counted only at the third edge, because of the synchroniser and the edge register.

A behavioural reference model in the bench advances at every rising edge. All outputs are compared against it at the following falling edge, so each result is sampled once it is due and before the next edge. Directed checks wait an exact number of edges that follows from these latencies: 2^P per timer tick, three per pin edge, one per write. Over fixed windows they count the output transitions, so R9 and R10 give distinct totals.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;

    // width of the prescale exponent field
    localparam int PSC_W  = 3;
    // number of control bits held in the control register
    localparam int CTRL_W = 11;

    // register addresses
    localparam int ADR_CTRL   = 0;
    localparam int ADR_COUNT  = 1;
    localparam int ADR_RELOAD = 2;
    localparam int ADR_CMP    = 3;
    localparam int ADR_FLAG   = 4;

    typedef enum logic [1:0] {
        EDG_NONE = 2'd0,
        EDG_RISE = 2'd1,
        EDG_FALL = 2'd2,
        EDG_BOTH = 2'd3
    } edge_sel_t;

    typedef enum logic {
        ST_STOP = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    // packed MSB first: psc[10:8] ext[7] edge[6:5] mode8[4] pol[3] oe[2] ie[1] run[0]
    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic             ext;
        edge_sel_t        edge_sel;
        logic             mode8;
        logic             pol;
        logic             oe;
        logic             ie;
        logic             run;
    } ctrl_t;

endpackage

// File: rtl/evt_ctr_tick_gen.sv
module evt_ctr_tick_gen
    import evt_ctr_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             ext_mode,
    input  edge_sel_t        edge_sel,
    input  logic [PSC_W-1:0] psc,
    input  logic             pin_i,
    output logic             tick
);

    localparam int PRE_W = (1 << PSC_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_mask;
    logic [SYNC_N:0]  sync_q;
    logic             pin_now;
    logic             pin_old;
    logic             ext_hit;
    logic             tmr_hit;

    // free-running prescaler, cleared while stopped so every start is aligned
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!running) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // synchroniser chain plus one history stage for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_N-1:0], pin_i};
        end
    end

    assign pin_now  = sync_q[SYNC_N-1];
    assign pin_old  = sync_q[SYNC_N];
    assign pre_mask = ~({PRE_W{1'b1}} << psc);
    assign tmr_hit  = ((pre_q & pre_mask) == pre_mask);

    always_comb begin
        unique case (edge_sel)
            EDG_NONE: ext_hit = 1'b0;
            EDG_RISE: ext_hit = pin_now & ~pin_old;
            EDG_FALL: ext_hit = ~pin_now & pin_old;
            EDG_BOTH: ext_hit = pin_now ^ pin_old;
        endcase
    end

    assign tick = running & (ext_mode ? ext_hit : tmr_hit);

    // R4: a pin-mode tick always comes from a change seen across the history stage
    a_r4_edge_source: assert property (@(posedge clk) disable iff (!rst_n)
        (running && ext_mode && tick) |-> (pin_now != pin_old));

endmodule

// File: rtl/evt_ctr_count_core.sv
module evt_ctr_count_core #(
    parameter int CNT_W    = 16,
    parameter int NARROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             mode8,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_evt,
    output logic             cmp_evt
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] narrow_top;
    logic [CNT_W-1:0] top_v;
    logic [CNT_W-1:0] view_v;
    logic [CNT_W-1:0] cmp_v;
    logic [CNT_W-1:0] rel_v;
    logic [CNT_W-1:0] ld_v;

    generate
        if (CNT_W > NARROW_W) begin : g_dual
            assign narrow_top = {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
        end else begin : g_single
            assign narrow_top = '1;
        end
    endgenerate

    assign top_v  = mode8 ? narrow_top : '1;
    assign view_v = cnt_q & top_v;
    assign cmp_v  = cmp_val & top_v;
    assign rel_v  = reload_val & top_v;
    assign ld_v   = load_val & top_v;

    // both events look at the count held before the tick is applied
    assign ovf_evt = tick & (view_v == top_v);
    assign cmp_evt = tick & (view_v == cmp_v);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_en) begin
            cnt_q <= ld_v;
        end else if (ovf_evt) begin
            cnt_q <= rel_v;
        end else if (tick) begin
            cnt_q <= view_v + 1'b1;
        end
    end

    assign cnt_o = view_v;

    // R5: an overflow without a software load leaves the reload value in the count
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !load_en) |=> (cnt_q == $past(rel_v)));

    // R13: no tick and no load means the count register keeps its value
    a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_en) |=> $stable(cnt_q));

endmodule

// File: rtl/evt_ctr_out_fsm.sv
module evt_ctr_out_fsm
    import evt_ctr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_req,
    input  logic pol_wr,
    input  logic pol_val,
    input  logic ovf_evt,
    input  logic cmp_evt,
    output logic running,
    output logic lvl_o
);

    run_state_t state_q;
    run_state_t state_d;
    logic       lvl_q;
    logic       flip;

    assign flip = ovf_evt | cmp_evt;

    // next-state logic: T_START and T_HALT
    always_comb begin
        unique case (state_q)
            ST_STOP: state_d = run_req ? ST_RUN : ST_STOP;
            ST_RUN:  state_d = run_req ? ST_RUN : ST_STOP;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    // output level: preset while stopped, one flip per event tick while running
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_STOP: if (pol_wr) lvl_q <= pol_val;
                ST_RUN:  if (flip)   lvl_q <= ~lvl_q;
            endcase
        end
    end

    assign running = (state_q == ST_RUN);
    assign lvl_o   = lvl_q;

    // R8: any event tick while running changes the level
    a_r8_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && flip) |=> (lvl_q != $past(lvl_q)));

    // R11: while running, only events move the level (polarity writes do not)
    a_r11_run_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !flip) |=> $stable(lvl_q));

endmodule

// File: rtl/evt_reload_ctr.sv
module evt_reload_ctr
    import evt_ctr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    input  logic              ev_pin_i,
    output logic              tgl_pin_o,
    output logic              tgl_oe_o,
    output logic              irq_o
);

    ctrl_t            ctrl_q;
    ctrl_t            ctrl_new;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cmp_q;
    logic             flag_q;
    logic [CNT_W-1:0] cnt_v;
    logic             ctrl_wr;
    logic             cnt_wr;
    logic             rel_wr;
    logic             cmp_wr;
    logic             flag_wr;
    logic             flag_clr;
    logic             tick;
    logic             running;
    logic             ovf_evt;
    logic             cmp_evt;
    logic             lvl;
    logic             run_req;

    assign ctrl_wr  = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));
    assign cnt_wr   = wr_en && (wr_addr == ADDR_W'(ADR_COUNT));
    assign rel_wr   = wr_en && (wr_addr == ADDR_W'(ADR_RELOAD));
    assign cmp_wr   = wr_en && (wr_addr == ADDR_W'(ADR_CMP));
    assign flag_wr  = wr_en && (wr_addr == ADDR_W'(ADR_FLAG));
    assign flag_clr = flag_wr && !wr_data[0];
    assign ctrl_new = ctrl_t'(wr_data[CTRL_W-1:0]);
    assign run_req  = ctrl_wr ? ctrl_new.run : ctrl_q.run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            reload_q <= '0;
            cmp_q    <= '0;
        end else begin
            if (ctrl_wr) ctrl_q   <= ctrl_new;
            if (rel_wr)  reload_q <= wr_data;
            if (cmp_wr)  cmp_q    <= wr_data;
        end
    end

    // sticky flag: a hardware set outranks a software clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (ovf_evt) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    evt_ctr_tick_gen u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .running  (running),
        .ext_mode (ctrl_q.ext),
        .edge_sel (ctrl_q.edge_sel),
        .psc      (ctrl_q.psc),
        .pin_i    (ev_pin_i),
        .tick     (tick)
    );

    evt_ctr_count_core #(
        .CNT_W    (CNT_W),
        .NARROW_W (8)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .mode8      (ctrl_q.mode8),
        .load_en    (cnt_wr),
        .load_val   (wr_data),
        .reload_val (reload_q),
        .cmp_val    (cmp_q),
        .cnt_o      (cnt_v),
        .ovf_evt    (ovf_evt),
        .cmp_evt    (cmp_evt)
    );

    evt_ctr_out_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_req (run_req),
        .pol_wr  (ctrl_wr),
        .pol_val (ctrl_new.pol),
        .ovf_evt (ovf_evt),
        .cmp_evt (cmp_evt),
        .running (running),
        .lvl_o   (lvl)
    );

    always_comb begin
        unique case (rd_addr)
            ADDR_W'(ADR_CTRL):   rd_data = CNT_W'(ctrl_q);
            ADDR_W'(ADR_COUNT):  rd_data = cnt_v;
            ADDR_W'(ADR_RELOAD): rd_data = reload_q;
            ADDR_W'(ADR_CMP):    rd_data = cmp_q;
            ADDR_W'(ADR_FLAG):   rd_data = CNT_W'(flag_q);
            default:             rd_data = '0;
        endcase
    end

    assign tgl_oe_o  = ctrl_q.oe;
    assign tgl_pin_o = ctrl_q.oe & lvl;
    assign irq_o     = flag_q & ctrl_q.ie;

    // R6: once set, the flag survives every cycle without a clear write
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);

    // R7: an overflow with the enable held raises the request on the next cycle
    a_r7_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && ctrl_q.ie && !ctrl_wr) |=> irq_o);

endmodule

// File: tb/tb_evt_reload_ctr.sv
`timescale 1ns/1ps
module tb_evt_reload_ctr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        ev_pin = 1'b0;
    logic        tgl_pin;
    logic        tgl_oe;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    evt_reload_ctr dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .ev_pin_i  (ev_pin),
        .tgl_pin_o (tgl_pin),
        .tgl_oe_o  (tgl_oe),
        .irq_o     (irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_run, m_ctl, m_cnt, m_rel, m_cmp, m_flag, m_lvl, m_pre, m_s1, m_s2, m_s3;
    int t_psc, t_msk, t_tk, t_cv, t_cm, t_top, t_ovf, t_ce, t_m8, t_ext, t_es, t_rise, t_fall;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_ctl = 0; m_cnt = 0; m_rel = 0; m_cmp = 0;
            m_flag = 0; m_lvl = 0; m_pre = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            t_m8  = (m_ctl >> 4) & 1;
            t_ext = (m_ctl >> 7) & 1;
            t_es  = (m_ctl >> 5) & 3;
            t_psc = (m_ctl >> 8) & 7;
            t_msk = (1 << t_psc) - 1;
            t_rise = (m_s2 == 1 && m_s3 == 0);
            t_fall = (m_s2 == 0 && m_s3 == 1);
            if (m_run == 0) t_tk = 0;
            else if (t_ext == 1)
                t_tk = ((t_es == 1 && t_rise) || (t_es == 2 && t_fall) ||
                        (t_es == 3 && (t_rise || t_fall))) ? 1 : 0;
            else t_tk = ((m_pre & t_msk) == t_msk) ? 1 : 0;
            t_top = t_m8 ? 255 : 65535;
            t_cv  = m_cnt & t_top;
            t_cm  = m_cmp & t_top;
            t_ovf = (t_tk == 1 && t_cv == t_top) ? 1 : 0;
            t_ce  = (t_tk == 1 && t_cv == t_cm) ? 1 : 0;
            if (wr_en && wr_addr == 1) m_cnt = int'(wr_data) & t_top;
            else if (t_ovf == 1)       m_cnt = m_rel & t_top;
            else if (t_tk == 1)        m_cnt = t_cv + 1;
            if (t_ovf == 1) m_flag = 1;
            else if (wr_en && wr_addr == 4 && !wr_data[0]) m_flag = 0;
            if (m_run == 0) begin
                if (wr_en && wr_addr == 0) m_lvl = int'(wr_data[3]);
            end else if (t_ovf == 1 || t_ce == 1) begin
                m_lvl = 1 - m_lvl;
            end
            m_pre = (m_run == 1) ? ((m_pre + 1) & 127) : 0;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(ev_pin);
            if (wr_en && wr_addr == 0) begin
                m_ctl = int'(wr_data) & 'h7FF;
                m_run = int'(wr_data[0]);
            end
            if (wr_en && wr_addr == 2) m_rel = int'(wr_data);
            if (wr_en && wr_addr == 3) m_cmp = int'(wr_data);
        end
    end

    function automatic int model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_ctl;
            3'd1: return m_cnt & ((((m_ctl >> 4) & 1) == 1) ? 255 : 65535);
            3'd2: return m_rel;
            3'd3: return m_cmp;
            3'd4: return m_flag;
            default: return 0;
        endcase
    endfunction

    // per-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R1", "rd_data vs model", 32'(rd_data), 32'(model_read(rd_addr)));
            check("R8", "tgl_oe_o vs model", 32'(tgl_oe), 32'((m_ctl >> 2) & 1));
            check("R8", "tgl_pin_o vs model", 32'(tgl_pin),
                  32'((((m_ctl >> 2) & 1) == 1) ? m_lvl : 0));
            check("R7", "irq_o vs model", 32'(irq),
                  32'((m_flag == 1 && ((m_ctl >> 1) & 1) == 1) ? 1 : 0));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(posedge clk); #1;
        rd_addr = a;
        @(negedge clk);
        v = rd_data;
    endtask

    task automatic pulse();
        @(posedge clk); #1; ev_pin = 1'b1;
        repeat (3) @(posedge clk);
        #1; ev_pin = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    task automatic count_toggles(output int n);
        logic p;
        n = 0;
        @(negedge clk); p = tgl_pin;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (tgl_pin != p) n++;
            p = tgl_pin;
        end
    endtask

    // watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, v2;
        int n;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R2 reset state, R1 unused address
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            check("R2", "register after reset", 32'(v), 32'h0);
        end
        check("R2", "pin after reset", 32'(tgl_pin), 32'h0);
        check("R2", "irq after reset", 32'(irq), 32'h0);
        rd(3'd5, v);
        check("R1", "unused address", 32'(v), 32'h0);

        // R5/R6/R7/R8: rising-edge counting with reload FFF8
        wr(3'd2, 16'hFFF8);
        rd(3'd2, v);
        check("R1", "reload readback", 32'(v), 32'hFFF8);
        wr(3'd1, 16'hFFF8);
        wr(3'd3, 16'h0000);
        wr(3'd0, 16'h00AF);
        check("R11", "pin preset from polarity", 32'(tgl_pin), 32'h1);
        for (int i = 0; i < 7; i++) pulse();
        rd(3'd1, v);
        check("R5", "count after 7 edges", 32'(v), 32'hFFFF);
        rd(3'd4, v);
        check("R6", "flag before overflow", 32'(v), 32'h0);
        pulse();
        rd(3'd4, v);
        check("R6", "flag after 8th edge", 32'(v), 32'h1);
        rd(3'd1, v);
        check("R5", "count reloaded", 32'(v), 32'hFFF8);
        check("R7", "irq raised", 32'(irq), 32'h1);
        check("R8", "pin toggled by overflow", 32'(tgl_pin), 32'h0);

        // R6 clear semantics
        wr(3'd4, 16'h0001);
        rd(3'd4, v);
        check("R6", "write 1 ignored", 32'(v), 32'h1);
        wr(3'd4, 16'h0000);
        rd(3'd4, v);
        check("R6", "write 0 clears", 32'(v), 32'h0);
        check("R7", "irq dropped", 32'(irq), 32'h0);

        // R4 edge codes
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h0000);
        wr(3'd0, 16'h00C1);
        for (int i = 0; i < 3; i++) pulse();
        rd(3'd1, v);
        check("R4", "falling-edge count", 32'(v), 32'd3);
        wr(3'd0, 16'h0081);
        for (int i = 0; i < 2; i++) pulse();
        rd(3'd1, v);
        check("R4", "edge code 00 counts nothing", 32'(v), 32'd3);
        wr(3'd0, 16'h00E1);
        for (int i = 0; i < 2; i++) pulse();
        rd(3'd1, v);
        check("R4", "both-edge count", 32'(v), 32'd7);

        // R3 timer mode, prescale 4
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h0000);
        rd_addr = 3'd1;
        wr(3'd0, 16'h0201);
        repeat (40) @(posedge clk);
        @(negedge clk);
        check("R3", "count after 40 clocks at /4", 32'(rd_data), 32'd10);

        // R13 hold while stopped
        wr(3'd0, 16'h0000);
        rd(3'd1, v);
        repeat (10) @(posedge clk);
        rd(3'd1, v2);
        check("R13", "count holds when stopped", 32'(v2), 32'(v));

        // R13 write priority over a tick
        wr(3'd0, 16'h0001);
        rd_addr = 3'd1;
        wr(3'd1, 16'h1234);
        @(negedge clk);
        check("R13", "written count", 32'(rd_data), 32'h1234);
        @(negedge clk);
        check("R13", "count resumes", 32'(rd_data), 32'h1235);

        // R9 compare equals reload: second transition one tick after reload
        wr(3'd0, 16'h0000);
        wr(3'd2, 16'hFFFE);
        wr(3'd3, 16'hFFFE);
        wr(3'd1, 16'hFFFE);
        wr(3'd0, 16'h0005);
        count_toggles(n);
        check("R9", "toggles in 16 ticks, cmp==reload", 32'(n), 32'd16);

        // R10 compare equals top: single transition per overflow
        wr(3'd0, 16'h0000);
        wr(3'd3, 16'hFFFF);
        wr(3'd1, 16'hFFFE);
        wr(3'd0, 16'h0005);
        count_toggles(n);
        check("R10", "toggles in 16 ticks, cmp==top", 32'(n), 32'd8);

        // R8 output enable gating, R11 polarity rules
        wr(3'd0, 16'h0008);
        check("R8", "pin gated off", 32'(tgl_pin), 32'h0);
        check("R8", "oe low", 32'(tgl_oe), 32'h0);
        wr(3'd0, 16'h000C);
        check("R11", "stopped polarity sets level", 32'(tgl_pin), 32'h1);
        wr(3'd1, 16'h0000);
        wr(3'd0, 16'h070D);
        wr(3'd0, 16'h0705);
        @(negedge clk);
        check("R11", "running polarity write ignored", 32'(tgl_pin), 32'h1);
        wr(3'd0, 16'h0000);

        // R12 narrow mode
        wr(3'd4, 16'h0000);
        wr(3'd0, 16'h0010);
        wr(3'd2, 16'h00F0);
        wr(3'd3, 16'h0000);
        wr(3'd1, 16'h12FD);
        rd(3'd1, v);
        check("R12", "narrow count write masked", 32'(v), 32'h00FD);
        rd_addr = 3'd1;
        wr(3'd0, 16'h0011);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R12", "narrow overflow at FF reloads", 32'(rd_data), 32'h00F0);
        rd(3'd4, v);
        check("R12", "narrow overflow sets flag", 32'(v), 32'h1);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule